// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port with Edge-Flag Detection

This block provides two 8-bit parallel ports, called A and B, on a simple register bus. Each port has a data register and a direction register with one bit per pin. A direction bit of 1 makes that pin an output. A pin set as an input is pulled high. Port A drives its pin levels out of the block. Port B reads back only: its output bits report the register and its input bits report the outside world.

Port A's top pin is watched by an edge detector whose polarity is chosen by a bus write. When that pin moves in the chosen direction, a sticky flag is raised in a status byte. The status byte also carries a timer flag that comes in from a neighbouring block. Reading the status byte clears the edge flag, but it leaves the timer flag alone. Both external input bytes pass through one register stage before they are read or edge-detected.

The bus is single-cycle. Writes take effect at the clock edge. Read data is combinational from the registered state, and the clear that a read causes is applied at the clock edge that ends the read cycle.

Top module: `pio_dual_port`

## Requirements
- R1: With address bit 2 low, a write to offset 0, 1, 2 or 3 (address bits 1:0) loads port A data, port A direction, port B data or port B direction respectively. Reading offsets 1 and 3 returns the direction registers unchanged.
- R2: The `pa_drive` byte equals port A data OR NOT port A direction, so every input pin drives high.
- R3: Reading offset 0 returns (port A data OR NOT port A direction) AND the sampled port A input. A change on `pa_in` appears in this read one clock after the change is presented.
- R4: Reading offset 2 returns (port B data OR NOT port B direction) AND (sampled port B input OR port B direction).
- R5: A write with address bit 2 high and address bit 4 low sets the edge polarity from address bit 0: 1 selects rising and 0 selects falling. A write with bits 2 and 4 both high changes nothing in this block.
- R6: The edge flag (status bit 6) is set one clock after a transition in the selected direction reaches the sampled bit 7 of port A. It is set exactly once per transition, and a transition in the other direction leaves it unchanged.
- R7: A read with address bit 2 high and bit 0 high (offset 5 or 7) returns `timer_flag_in` at bit 7 and the edge flag at bit 6. The edge flag is cleared at the end of that cycle. If a new edge is detected in the same cycle, the flag stays set.
- R8: After reset, both data registers, both direction registers and the edge flag are zero, falling-edge polarity is selected, and the input sampling stages hold all ones.
- R9: A read with address bit 2 high and bit 0 low returns zero, and status bits 5:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies the flag clear on status reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pa_in | input | 8 | External levels on port A pins |
| pb_in | input | 8 | External levels on port B pins |
| pa_drive | output | 8 | Levels driven onto port A pins |
| timer_flag_in | input | 1 | Timer flag from the neighbouring timer, shown at status bit 7 |

## Verification
The edge flag can be raised and cleared in the same cycle. This happens when a status read lands in the cycle where the sampled bit 7 of port A has just made a selected transition. The bench provokes it by issuing status reads on every cycle around a pin transition, so that one read falls exactly on the detection cycle. The expected outcome is that the read returns the old flag value and the flag is still set afterwards. A second collision, a polarity write in the same cycle as a pin transition, is also exercised. The behavioural model predicts the outcome of every cycle, so both collisions are judged by the same per-cycle comparison.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Address bit positions that steer decoding
  localparam int ADR_UPPER_BIT = 2;  // 0: port registers, 1: status/control window
  localparam int ADR_TMR_BIT   = 4;  // 1 with upper: timer writes (not ours)
  localparam int ADR_POL_BIT   = 0;  // polarity value on control writes

  // Status byte layout
  localparam int STAT_TMR_BIT  = 7;
  localparam int STAT_EDGE_BIT = 6;

  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_DIR  = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_DIR  = 2'd3
  } pio_sel_e;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } pio_pol_e;

endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];

endmodule

// File: rtl/pio_port_bank.sv
module pio_port_bank #(
  parameter int WIDTH    = 8,
  parameter bit READS_B  = 1'b0   // 0: port A read-back, 1: port B read-back
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_i,
  input  logic             wr_dir_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_raw_i,
  output logic [WIDTH-1:0] pin_drive_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] samp_o
);

  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] dir_q,  dir_d;
  logic [WIDTH-1:0] samp_q;
  logic [WIDTH-1:0] level;

  // Next-state for the register file
  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (wr_data_i) data_d = wdata_i;
    if (wr_dir_i)  dir_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data_i || wr_dir_i) begin
        data_q <= data_d;
        dir_q  <= dir_d;
      end
    end
  end

  // One sampling stage on the external levels; idle pins are pulled high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= '1;
    else        samp_q <= pin_raw_i;
  end

  // Output register wins on output pins, input pins float high
  assign level = data_q | ~dir_q;

  generate
    if (READS_B) begin : g_rd_b
      assign rd_data_o = level & (samp_q | dir_q);
    end else begin : g_rd_a
      assign rd_data_o = level & samp_q;
    end
  endgenerate

  assign pin_drive_o = level;
  assign dir_o       = dir_q;
  assign samp_o      = samp_q;

  // R1: direction write lands next cycle
  assert_dir_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_dir_i) |-> dir_q == $past(wdata_i));

  // R2: no input-mode pin is ever driven low
  assert_input_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q) & ~pin_drive_o) == '0);

endmodule

// File: rtl/pio_edge_flag.sv
module pio_edge_flag
  import pio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,      // already sampled pin level
  input  logic pol_wr_i,
  input  logic pol_val_i,
  input  logic clr_i,
  output logic flag_o
);

  pio_pol_e pol_q, pol_d;
  logic     prev_q;
  logic     flag_q, flag_d;
  logic     hit;

  always_comb begin
    pol_d = pol_q;
    if (pol_wr_i) pol_d = pio_pol_e'(pol_val_i);
  end

  // Transition detect against the previous sampled level
  always_comb begin
    if (pol_q == POL_RISE) hit = samp_i & ~prev_q;
    else                   hit = ~samp_i & prev_q;
  end

  // Set has priority over the read-clear
  always_comb begin
    flag_d = (flag_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= POL_FALL;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (pol_wr_i) pol_q <= pol_d;
      prev_q <= samp_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R6: flag only rises after the sampled level moved
  assert_rise_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(samp_i != prev_q));

  // R7: flag only drops after a status read
  assert_fall_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));

endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pa_drive,
  input  logic              timer_flag_in
);

  localparam int EDGE_PIN = DATA_W - 1;

  logic rst_int_n;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  // Address decode
  logic     in_ports, in_ctrl;
  pio_sel_e sel;
  logic     wr_a_data, wr_a_dir, wr_b_data, wr_b_dir;
  logic     pol_wr, stat_rd;

  always_comb begin
    in_ports  = ~bus_addr[ADR_UPPER_BIT];
    in_ctrl   =  bus_addr[ADR_UPPER_BIT];
    sel       = pio_sel_e'(bus_addr[1:0]);
    wr_a_data = bus_wr & in_ports & (sel == SEL_A_DATA);
    wr_a_dir  = bus_wr & in_ports & (sel == SEL_A_DIR);
    wr_b_data = bus_wr & in_ports & (sel == SEL_B_DATA);
    wr_b_dir  = bus_wr & in_ports & (sel == SEL_B_DIR);
    pol_wr    = bus_wr & in_ctrl & ~bus_addr[ADR_TMR_BIT];
    stat_rd   = bus_rd & in_ctrl & bus_addr[0];
  end

  logic [DATA_W-1:0] a_rd, a_dir, a_samp, a_drive;
  logic [DATA_W-1:0] b_rd, b_dir, b_samp, b_drive;

  pio_port_bank #(.WIDTH(DATA_W), .READS_B(1'b0)) u_port_a (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_data_i   (wr_a_data),
    .wr_dir_i    (wr_a_dir),
    .wdata_i     (bus_wdata),
    .pin_raw_i   (pa_in),
    .pin_drive_o (a_drive),
    .rd_data_o   (a_rd),
    .dir_o       (a_dir),
    .samp_o      (a_samp)
  );

  pio_port_bank #(.WIDTH(DATA_W), .READS_B(1'b1)) u_port_b (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_data_i   (wr_b_data),
    .wr_dir_i    (wr_b_dir),
    .wdata_i     (bus_wdata),
    .pin_raw_i   (pb_in),
    .pin_drive_o (b_drive),
    .rd_data_o   (b_rd),
    .dir_o       (b_dir),
    .samp_o      (b_samp)
  );

  logic edge_flag;

  pio_edge_flag u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .samp_i    (a_samp[EDGE_PIN]),
    .pol_wr_i  (pol_wr),
    .pol_val_i (bus_addr[ADR_POL_BIT]),
    .clr_i     (stat_rd),
    .flag_o    (edge_flag)
  );

  // Read mux
  logic [DATA_W-1:0] status;

  always_comb begin
    status                = '0;
    status[STAT_TMR_BIT]  = timer_flag_in;
    status[STAT_EDGE_BIT] = edge_flag;
  end

  always_comb begin
    bus_rdata = '0;
    if (in_ports) begin
      unique case (sel)
        SEL_A_DATA: bus_rdata = a_rd;
        SEL_A_DIR:  bus_rdata = a_dir;
        SEL_B_DATA: bus_rdata = b_rd;
        SEL_B_DIR:  bus_rdata = b_dir;
        default:    bus_rdata = '0;
      endcase
    end else if (bus_addr[0]) begin
      bus_rdata = status;
    end
  end

  assign pa_drive = a_drive;

  logic unused_sig;
  assign unused_sig = ^{a_samp[EDGE_PIN-1:0], b_samp, b_drive, bus_addr[3]};

  // R9: unused status bits stay zero on status reads
  assert_stat_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && bus_addr[ADR_UPPER_BIT] && bus_addr[0]) |-> bus_rdata[STAT_EDGE_BIT-1:0] == '0);

endmodule

// File: tb/tb_pio_dual_port.sv
`timescale 1ns/1ps
module tb_pio_dual_port;

  logic       clk;
  logic       rst_n;
  logic [4:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pa_in, pb_in, pa_drive;
  logic       timer_flag_in;

  pio_dual_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pb_in(pb_in), .pa_drive(pa_drive),
    .timer_flag_in(timer_flag_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // Behavioural model state
  logic [7:0] m_ora, m_dda, m_orb, m_ddb, m_sa, m_sb;
  logic       m_pol, m_flag, m_prev;

  task automatic model_reset();
    m_ora = 8'h00; m_dda = 8'h00; m_orb = 8'h00; m_ddb = 8'h00;
    m_sa = 8'hFF; m_sb = 8'hFF;   // R8 sampling stages all ones
    m_pol = 1'b0; m_flag = 1'b0; m_prev = 1'b1;
  endtask

  function automatic logic [7:0] model_read(input logic [4:0] a, input logic tf);
    logic [7:0] r;
    r = 8'h00;
    if (!a[2]) begin
      case (a[1:0])
        2'd0: r = (m_ora | ~m_dda) & m_sa;
        2'd1: r = m_dda;
        2'd2: r = (m_orb | ~m_ddb) & (m_sb | m_ddb);
        default: r = m_ddb;
      endcase
    end else if (a[0]) begin
      r = {tf, m_flag, 6'b000000};
    end
    return r;
  endfunction

  function automatic string read_tag(input logic [4:0] a);
    if (!a[2]) begin
      case (a[1:0])
        2'd0: return "R3";
        2'd2: return "R4";
        default: return "R1";
      endcase
    end
    return a[0] ? "R7" : "R9";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive, compare before the edge, advance model
  task automatic step(input logic [4:0] a, input logic wr, input logic rd,
                      input logic [7:0] wd, input logic [7:0] pa,
                      input logic [7:0] pb, input logic tf);
    logic hit, clr;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    pa_in = pa; pb_in = pb; timer_flag_in = tf;
    #1;
    check("R2", pa_drive, m_ora | ~m_dda);
    if (rd) check(read_tag(a), bus_rdata, model_read(a, tf));
    hit = m_pol ? (m_sa[7] & ~m_prev) : (~m_sa[7] & m_prev);
    clr = rd & a[2] & a[0];
    if (wr && !a[2]) begin
      case (a[1:0])
        2'd0: m_ora = wd;
        2'd1: m_dda = wd;
        2'd2: m_orb = wd;
        default: m_ddb = wd;
      endcase
    end
    if (wr && a[2] && !a[4]) m_pol = a[0];
    m_prev = m_sa[7];
    m_sa = pa;
    m_sb = pb;
    m_flag = (m_flag & ~clr) | hit;
  endtask

  logic [7:0] cur_pa, cur_pb;
  logic       cur_tf;

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    step(a, 1'b1, 1'b0, d, cur_pa, cur_pb, cur_tf);
  endtask
  task automatic rd_reg(input logic [4:0] a);
    step(a, 1'b0, 1'b1, 8'h00, cur_pa, cur_pb, cur_tf);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(5'd0, 1'b0, 1'b0, 8'h00, cur_pa, cur_pb, cur_tf);
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    pa_in = 8'hFF; pb_in = 8'hFF; timer_flag_in = 0;
    cur_pa = 8'hFF; cur_pb = 8'hFF; cur_tf = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    // R8: reset state through all readable offsets
    for (int k = 0; k < 4; k++) rd_reg(5'(k));
    rd_reg(5'd5);

    // R1/R2/R3: port A direction mix and pin patterns
    wr_reg(5'd1, 8'hF0);
    wr_reg(5'd0, 8'hA5);
    rd_reg(5'd1);
    cur_pa = 8'h3C; idle(1); rd_reg(5'd0);
    cur_pa = 8'hFF; idle(1); rd_reg(5'd0);
    cur_pa = 8'h00; rd_reg(5'd0); rd_reg(5'd0);   // one-cycle sampling delay, R3
    wr_reg(5'd1, 8'h0F); cur_pa = 8'h5A; idle(1); rd_reg(5'd0);

    // R4: port B mixes
    wr_reg(5'd3, 8'h0F);
    wr_reg(5'd2, 8'h3C);
    cur_pb = 8'h00; idle(1); rd_reg(5'd2);
    cur_pb = 8'hF0; idle(1); rd_reg(5'd2);
    wr_reg(5'd3, 8'h00); rd_reg(5'd2); rd_reg(5'd3);

    // R6: falling edge default; flag set once, cleared by read (R7)
    wr_reg(5'd1, 8'h00);
    cur_pa = 8'hFF; idle(2);
    cur_pa = 8'h7F; idle(3); rd_reg(5'd5); rd_reg(5'd7);
    idle(3); rd_reg(5'd5);                        // held low: no re-set
    cur_pa = 8'hFF; idle(3); rd_reg(5'd5);        // rising ignored on falling

    // R5: select rising; timer-region write must not flip it back
    wr_reg(5'd5, 8'h00);
    wr_reg(5'd20, 8'h00);                         // bits 4 and 2 set, bit 0 low
    cur_pa = 8'h7F; idle(3); rd_reg(5'd5);        // falling: no flag
    cur_pa = 8'hFF; idle(3); rd_reg(5'd5); rd_reg(5'd5);

    // R7 collision: status read every cycle across a transition
    cur_pa = 8'h7F; idle(1);
    cur_pa = 8'hFF;
    for (int k = 0; k < 5; k++) rd_reg(5'd7);
    cur_pa = 8'h7F;
    for (int k = 0; k < 5; k++) rd_reg(5'd5);

    // Polarity write in the same cycle as a transition (R5/R6)
    step(5'd4, 1'b1, 1'b0, 8'h00, 8'hFF, cur_pb, cur_tf);
    cur_pa = 8'hFF;
    for (int k = 0; k < 4; k++) rd_reg(5'd5);

    // R7/R9: timer flag pass-through, timer-offset reads are zero
    cur_tf = 1; rd_reg(5'd5); rd_reg(5'd4); rd_reg(5'd6);
    cur_tf = 0; rd_reg(5'd7);

    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [4:0] a;
      logic [1:0] op;
      a  = 5'($urandom_range(0, 31));
      op = 2'($urandom_range(0, 3));
      cur_pa = ($urandom_range(0, 3) == 0) ? 8'($urandom) : cur_pa;
      cur_pb = 8'($urandom);
      cur_tf = 1'($urandom);
      step(a, op == 2'd0, op[1], 8'($urandom), cur_pa, cur_pb, cur_tf);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule